// File: doc/BRIEF.md
# Triple-Voted Frame Rate Divider

This block turns the fast bit clock of a serializer into the frame timing of a 120-bit frame. Every 120 cycles it pulses a one-cycle strobe that loads the next word into the shift register. It also produces a frame-rate clock with a 50% duty cycle. A single skipped or doubled count would knock the downstream phase-locked loop out of lock and cause a long error burst. For that reason the count is held in three identical registers.

Each register bit reloads every cycle from the bitwise majority of the three copies, advanced by one. An upset in one copy is therefore outvoted at once and overwritten at the next edge. It never reaches the count sequence. A flag reports any cycle in which the copies disagree.

An upset-injection input exists for test. Each bit of it inverts one stored bit of one copy at the next edge, in the same way a particle strike would. In use it is tied to zero.

Top module: `frame_divider`

## Requirements
- R1: A synchronous reset sets all three copies to count 0. The cycle after a reset edge shows load_strobe low, frame_clk high and vote_mismatch low.
- R2: With no upsets, load_strobe is high for exactly one cycle at count 119. This happens after the 119th non-reset edge and then every 120 cycles.
- R3: frame_clk is high while the voted count is 0 to 59 and low while it is 60 to 119. After a strobe cycle it goes high.
- R4: A single-bit upset in one copy, applied at any cycle, leaves the strobe period at exactly 120 cycles and leaves frame_clk unchanged.
- R5: vote_mismatch is high for exactly the one cycle after an edge at which an upset was applied. It is low again after the next edge, provided no new upset was applied.
- R6: Upsets applied at the same edge to different bit positions, each in a different copy, are all corrected. The count sequence is unaffected.
- R7: When reset and upset are applied at the same edge, reset wins and all copies become zero with no mismatch.
- R8: A reset in the middle of a frame restarts the sequence. The next strobe comes after 119 further non-reset edges.
- R9: The upset input is a 3×W vector. Bits [k*W +: W] invert copy k, with W = 7 for a divide ratio of 120.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous reset, active high |
| upset_i | input | 3*W | Test-only upset injection; each bit inverts one stored bit of one copy at the next edge |
| load_strobe | output | 1 | One-cycle shift-register load pulse, once per 120 cycles |
| frame_clk | output | 1 | Frame-rate clock, high for counts 0 to 59 |
| vote_mismatch | output | 1 | High in any cycle where a copy differs from the voted count |

## Verification
The hardest case to reach is a copy that disagrees with the other two, because a correct voter hides this state from the count outputs. The bench drives the upset-injection input at pseudo-random cycles, choosing a random copy and bit. It checks that the strobe and frame clock still follow an independent edge-count model, and that the mismatch flag rises for exactly one cycle. It also injects simultaneous upsets in separate copies and bits, and upsets coinciding with reset.

// File: rtl/frame_divider.sv
module frame_divider #(
  parameter int DIV = 120,
  localparam int W = $clog2(DIV)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [3*W-1:0] upset_i,
  output logic           load_strobe,
  output logic           frame_clk,
  output logic           vote_mismatch
);

  logic [W-1:0] copy_q [3];
  logic [W-1:0] voted;
  logic [W-1:0] next_cnt;

  assign voted = (copy_q[0] & copy_q[1]) | (copy_q[0] & copy_q[2]) | (copy_q[1] & copy_q[2]);
  assign next_cnt = (voted == W'(DIV-1)) ? '0 : voted + W'(1);

  // every copy reloads from the voted next state, so a flipped copy heals in one edge
  always_ff @(posedge clk) begin
    for (int k = 0; k < 3; k++) begin
      if (rst) copy_q[k] <= '0;
      else     copy_q[k] <= next_cnt ^ upset_i[k*W +: W];
    end
  end

  assign load_strobe   = (voted == W'(DIV-1));
  assign frame_clk     = (voted < W'(DIV/2));
  assign vote_mismatch = (copy_q[0] != voted) || (copy_q[1] != voted) || (copy_q[2] != voted);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!load_strobe && frame_clk && !vote_mismatch));

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
    load_strobe |=> !load_strobe);

  assert_frame_after_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    load_strobe |=> frame_clk);

  assert_count_advance_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> voted == (($past(voted) == W'(DIV-1)) ? '0 : $past(voted) + W'(1)));

  assert_mismatch_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (vote_mismatch && upset_i == '0) |=> !vote_mismatch);

  assert_mismatch_source_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(upset_i) == '0) |-> !vote_mismatch);

endmodule

// File: tb/frame_divider_bench.sv
module frame_divider_bench;
  localparam int DIV = 120;
  localparam int W = $clog2(DIV);

  logic clk = 0;
  logic rst = 1;
  logic [3*W-1:0] upset_i = '0;
  logic load_strobe, frame_clk, vote_mismatch;

  int tests = 0;
  int fails = 0;
  int exp_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  frame_divider #(.DIV(DIV)) u_frame_divider (
    .clk(clk), .rst(rst), .upset_i(upset_i),
    .load_strobe(load_strobe), .frame_clk(frame_clk), .vote_mismatch(vote_mismatch)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (model count %0d)", req, what, act, exp, exp_cnt);
    end
  endtask

  // one edge: update the independent model, then check all outputs
  task automatic tick(input string req);
    bit r_at_edge;
    bit up_at_edge;
    r_at_edge  = rst;
    up_at_edge = (upset_i != '0);
    @(posedge clk); #1;
    if (r_at_edge) exp_cnt = 0;
    else exp_cnt = (exp_cnt == DIV-1) ? 0 : exp_cnt + 1;
    chk(req, "load_strobe", int'(load_strobe), int'(exp_cnt == DIV-1));
    chk(req, "frame_clk", int'(frame_clk), int'(exp_cnt < DIV/2));
    chk(req, "vote_mismatch", int'(vote_mismatch), int'(!r_at_edge && up_at_edge));
    upset_i = '0;
  endtask

  task automatic t_reset_R1();
    rst = 1;
    tick("R1");
    tick("R1");
    rst = 0;
  endtask

  task automatic t_period_R2_R3();
    int last = -1;
    int gaps = 0;
    for (int i = 1; i <= 3*DIV; i++) begin
      tick("R2/R3");
      if (load_strobe) begin
        if (last < 0) chk("R2", "first strobe edge", i, DIV-1);
        else chk("R2", "strobe period", i - last, DIV);
        last = i;
        gaps++;
      end
    end
    chk("R2", "strobes seen", gaps, 3);
  endtask

  task automatic t_single_upsets_R4_R5();
    int last = -1;
    int injected = 0;
    int cool = 0;
    for (int i = 0; i < 8*DIV; i++) begin
      if (cool == 0 && ($urandom % 7) == 0) begin
        upset_i = '0;
        upset_i[($urandom % 3)*W + ($urandom % W)] = 1'b1;
        injected++;
        cool = 2;
      end else if (cool > 0) cool--;
      tick("R4/R5");
      if (load_strobe) begin
        if (last >= 0) chk("R4", "strobe period under upsets", i - last, DIV);
        last = i;
      end
    end
    chk("R4", "upsets injected", int'(injected > 20), 1);
  endtask

  task automatic t_multi_R6();
    for (int j = 0; j < 40; j++) begin
      upset_i = '0;
      upset_i[0*W + (j % W)]       = 1'b1;
      upset_i[1*W + ((j+2) % W)]   = 1'b1;
      upset_i[2*W + ((j+4) % W)]   = 1'b1;
      tick("R6");
      tick("R6");
      tick("R6");
    end
  endtask

  task automatic t_reset_override_R7();
    rst = 1;
    upset_i = {3*W{1'b1}};
    tick("R7");
    chk("R7", "frame_clk after reset with upset", int'(frame_clk), 1);
    rst = 0;
    tick("R7");
  endtask

  task automatic t_midrun_R8();
    int seen = -1;
    for (int i = 0; i < 50; i++) tick("R8");
    rst = 1;
    tick("R8");
    rst = 0;
    for (int i = 1; i <= DIV+5; i++) begin
      tick("R8");
      if (load_strobe && seen < 0) seen = i;
    end
    chk("R8", "first strobe after midrun reset", seen, DIV-1);
  endtask

  initial begin
    #1;
    t_reset_R1();
    t_period_R2_R3();
    t_single_upsets_R4_R5();
    t_multi_R6();
    t_reset_override_R7();
    t_midrun_R8();
    // R9: field layout is exercised by the per-copy masks built above
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule